// File: doc/BRIEF.md
# Frequency-Change Watchdog Controller

This block protects a clock generator against a software frequency change that hangs the system. Software first sets a timeout of 1 to 15 seconds in a 4-bit field, then writes a new frequency, either as new dial-frequency values or as new software frequency-select bits. That write starts a seconds countdown. If the system survives and software writes the timeout field back to zero in time, the countdown stops and the new frequency stays in effect.

If the countdown runs out, the block sets an alarm flag. It then forces the selected frequency code back to a safe value and drives an active-low system reset pulse. The safe value is either the strap code latched by hardware or the software code that was in place before the failing one, and a revert-select bit chooses between the two. The reset pulse only reaches the pin when the shared pin is set up as a reset output. When the pin is set up as the PCI-stop input, the pulse is suppressed. A prescaler on the reference clock makes the one-second tick and times the reset pulse. Both divide values are parameters.

Top module: `freqwd_ctrl`

## Requirements
- R1: After reset, `sys_rst_n` is 1 and `alarm` is 0. `freq_code` equals `hw_code` while `sw_sel` is 0.
- R2: A frequency write (`dial_wr` or `fsel_wr` high at a clock edge) starts the countdown only if `tmo_sel` is nonzero at that edge. A write made with `tmo_sel` = 0 never raises `alarm`. Setting `tmo_sel` nonzero without a write does not raise it either.
- R3: With `tmo_sel` = N (1..15) at the arming write, `alarm` becomes 1 after exactly N×SEC_CYC clock edges following the arming edge, and not earlier. This holds for both kinds of write.
- R4: If `tmo_sel` is 0 at any edge before expiry, the countdown stops. No alarm and no reset pulse follow, and `freq_code` keeps the newly written software code.
- R5: Once set, `alarm` stays 1 while `tmo_sel` is nonzero. It is 0 after the first edge at which `tmo_sel` is 0.
- R6: On expiry with `revert_prev` = 0, `freq_code` becomes the `hw_code` value present at the expiry edge.
- R7: On expiry with `revert_prev` = 1, `freq_code` becomes the software code written by the `fsel_wr` before the most recent one.
- R8: On expiry with `revert_prev` = 1 and fewer than two `fsel_wr` writes since reset, `freq_code` becomes `hw_code`.
- R9: On expiry, with `pin_stop_mode` = 0, `sys_rst_n` goes to 0 from the expiry edge and stays low for exactly PULSE_CYC clock cycles.
- R10: With `pin_stop_mode` = 1, `sys_rst_n` stays 1 through an expiry. `alarm` is still set.
- R11: An arming write made while a countdown runs restarts the full period from that write.
- R12: Without a revert, `freq_code` is the last `fsel_wr` code when `sw_sel` = 1 and is `hw_code` otherwise. A forced revert code holds until the next `fsel_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_sel | input | 4 | Timeout in seconds, 0 = off |
| revert_prev | input | 1 | Revert target: 0 = hardware strap, 1 = previous software code |
| pin_stop_mode | input | 1 | Shared pin role: 1 = PCI-stop input, 0 = reset output |
| sw_sel | input | 1 | 1 = software frequency code in use |
| hw_code | input | 5 | Strap-latched frequency code |
| sw_code | input | 5 | Software frequency code, captured on `fsel_wr` |
| fsel_wr | input | 1 | Strobe: software frequency-select write |
| dial_wr | input | 1 | Strobe: dial-frequency value write |
| sys_rst_n | output | 1 | Active-low system reset pulse |
| alarm | output | 1 | Watchdog expiry flag |
| freq_code | output | 5 | Selected frequency code |

## Verification
The bench builds the block with SEC_CYC = 20 and PULSE_CYC = 6. With these values a three-second timeout takes only 60 cycles, and the whole reset pulse can be checked cycle by cycle. Exact expiry edges, restarts during a running countdown, and early cancellation one second into a two-second window all fit in a short run. With the default values, one second is millions of cycles and cannot be reached in a test.

// File: rtl/freqwd_pkg.sv
package freqwd_pkg;
  localparam int FW_CODE_W = 5;
  localparam int FW_TMO_W  = 4;

  typedef logic [FW_CODE_W-1:0] fw_code_t;
  typedef logic [FW_TMO_W-1:0]  fw_tmo_t;

  // Where the forced code after an expiry comes from
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_HW   = 2'd1,
    SRC_PREV = 2'd2
  } fw_src_e;
endpackage

// File: rtl/freqwd_tick.sv
module freqwd_tick #(
  parameter int SEC_CYC = 14_318_180
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (SEC_CYC > 2) ? $clog2(SEC_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SEC_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && !restart && (cnt_q == LAST);
endmodule

// File: rtl/freqwd_countdown.sv
module freqwd_countdown
  import freqwd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    arm,
  input  logic    stop,
  input  fw_tmo_t load_val,
  input  logic    tick,
  output logic    running,
  output logic    expire
);
  fw_tmo_t secs_q;
  logic    run_q;

  assign expire  = run_q && tick && !stop && !arm && (secs_q == fw_tmo_t'(1));
  assign running = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      secs_q <= '0;
    end else if (stop) begin
      run_q  <= 1'b0;
      secs_q <= '0;
    end else if (arm) begin
      run_q  <= 1'b1;
      secs_q <= load_val;
    end else if (expire) begin
      run_q  <= 1'b0;
      secs_q <= '0;
    end else if (run_q && tick) begin
      secs_q <= secs_q - 1'b1;
    end
  end
endmodule

// File: rtl/freqwd_history.sv
module freqwd_history
  import freqwd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  fw_code_t sw_code,
  input  logic     sw_sel,
  input  fw_code_t hw_code,
  input  logic     expire,
  input  logic     revert_prev,
  output fw_code_t freq_code
);
  fw_code_t cur_q, prev_q, ovr_q;
  logic     cur_v, prev_v;
  fw_src_e  src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
      cur_v  <= 1'b0;
      prev_v <= 1'b0;
      ovr_q  <= '0;
      src_q  <= SRC_NONE;
    end else if (wr) begin
      prev_q <= cur_q;
      prev_v <= cur_v;
      cur_q  <= sw_code;
      cur_v  <= 1'b1;
      src_q  <= SRC_NONE;
    end else if (expire) begin
      if (revert_prev && prev_v) begin
        ovr_q <= prev_q;
        src_q <= SRC_PREV;
      end else begin
        ovr_q <= hw_code;
        src_q <= SRC_HW;
      end
    end
  end

  always_comb begin
    if (src_q != SRC_NONE) begin
      freq_code = ovr_q;
    end else if (sw_sel && cur_v) begin
      freq_code = cur_q;
    end else begin
      freq_code = hw_code;
    end
  end
endmodule

// File: rtl/freqwd_pulse.sv
module freqwd_pulse #(
  parameter int PULSE_CYC = 85_909
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam int PW = $clog2(PULSE_CYC + 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (fire) begin
      left_q <= PW'(PULSE_CYC);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/freqwd_ctrl.sv
module freqwd_ctrl
  import freqwd_pkg::*;
#(
  parameter int SEC_CYC   = 14_318_180,
  parameter int PULSE_CYC = 85_909
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] tmo_sel,
  input  logic       revert_prev,
  input  logic       pin_stop_mode,
  input  logic       sw_sel,
  input  logic [4:0] hw_code,
  input  logic [4:0] sw_code,
  input  logic       fsel_wr,
  input  logic       dial_wr,
  output logic       sys_rst_n,
  output logic       alarm,
  output logic [4:0] freq_code
);
  logic tmo_off, arm, tick, running, expire, pulse_on, alarm_q;

  assign tmo_off = (tmo_sel == '0);
  assign arm     = (fsel_wr || dial_wr) && !tmo_off;

  freqwd_tick #(.SEC_CYC(SEC_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(running), .restart(arm), .tick(tick)
  );

  freqwd_countdown u_cnt (
    .clk(clk), .rst_n(rst_n), .arm(arm), .stop(tmo_off),
    .load_val(tmo_sel), .tick(tick), .running(running), .expire(expire)
  );

  freqwd_history u_hist (
    .clk(clk), .rst_n(rst_n), .wr(fsel_wr), .sw_code(sw_code),
    .sw_sel(sw_sel), .hw_code(hw_code), .expire(expire),
    .revert_prev(revert_prev), .freq_code(freq_code)
  );

  freqwd_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(expire), .active(pulse_on)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= 1'b0;
    end else if (tmo_off) begin
      alarm_q <= 1'b0;
    end else if (expire) begin
      alarm_q <= 1'b1;
    end
  end

  assign alarm     = alarm_q;
  assign sys_rst_n = !(pulse_on && !pin_stop_mode);
endmodule

// File: rtl/freqwd_chk.sv
module freqwd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] tmo_sel,
  input logic       revert_prev,
  input logic       pin_stop_mode,
  input logic [4:0] hw_code,
  input logic       sys_rst_n,
  input logic       alarm,
  input logic [4:0] freq_code
);
  // R10: the reset pin is never driven while it serves as the stop input
  a_r10_no_pulse_in_stop_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst_n |-> !pin_stop_mode);

  // R5: a zero timeout field clears the alarm by the next edge
  a_r5_alarm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_sel == 4'd0) |=> !alarm);

  // R2: an alarm only rises from an edge with a nonzero field
  a_r2_rise_needs_field: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> ($past(tmo_sel) != 4'd0));

  // R9: the pulse starts together with the alarm in reset-output mode
  a_r9_pulse_with_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(alarm) && !pin_stop_mode) |-> !sys_rst_n);

  // R6: a strap revert shows the strap code from the expiry edge
  a_r6_strap_revert: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(alarm) && !$past(revert_prev)) |-> (freq_code == $past(hw_code)));
endmodule

bind freqwd_ctrl freqwd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tmo_sel(tmo_sel), .revert_prev(revert_prev),
  .pin_stop_mode(pin_stop_mode), .hw_code(hw_code), .sys_rst_n(sys_rst_n),
  .alarm(alarm), .freq_code(freq_code)
);

// File: tb/freqwd_ctrl_tb_top.sv
`timescale 1ns/1ps
module freqwd_ctrl_tb_top;
  localparam int SEC = 20;
  localparam int PUL = 6;
  localparam logic [4:0] HW = 5'd13;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tmo_sel = '0;
  logic       revert_prev = 1'b0;
  logic       pin_stop_mode = 1'b0;
  logic       sw_sel = 1'b0;
  logic [4:0] hw_code = HW;
  logic [4:0] sw_code = '0;
  logic       fsel_wr = 1'b0;
  logic       dial_wr = 1'b0;
  logic       sys_rst_n, alarm;
  logic [4:0] freq_code;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  freqwd_ctrl #(.SEC_CYC(SEC), .PULSE_CYC(PUL)) dut_i (
    .clk(clk), .rst_n(rst_n), .tmo_sel(tmo_sel), .revert_prev(revert_prev),
    .pin_stop_mode(pin_stop_mode), .sw_sel(sw_sel), .hw_code(hw_code),
    .sw_code(sw_code), .fsel_wr(fsel_wr), .dial_wr(dial_wr),
    .sys_rst_n(sys_rst_n), .alarm(alarm), .freq_code(freq_code)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tmo_sel = '0; revert_prev = 1'b0; pin_stop_mode = 1'b0;
    sw_sel = 1'b0; fsel_wr = 1'b0; dial_wr = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
  endtask

  task automatic pulse_fsel(input logic [4:0] code);
    @(negedge clk);
    sw_code = code; fsel_wr = 1'b1;
    @(negedge clk);
    fsel_wr = 1'b0;
  endtask

  task automatic pulse_dial();
    @(negedge clk);
    dial_wr = 1'b1;
    @(negedge clk);
    dial_wr = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 sys_rst_n", sys_rst_n, 1);
    chk("R1 alarm", alarm, 0);
    chk("R1 freq_code", freq_code, HW);
  endtask

  task automatic t_no_arm();
    do_reset();
    pulse_dial();
    wait_cyc(2 * SEC + 2);
    chk("R2 write with field 0", alarm, 0);
    tmo_sel = 4'd1;
    wait_cyc(2 * SEC + 2);
    chk("R2 field alone", alarm, 0);
    chk("R2 no pulse", sys_rst_n, 1);
  endtask

  task automatic t_dial_expiry();
    do_reset();
    tmo_sel = 4'd3;
    pulse_dial();
    wait_cyc(3 * SEC - 1);
    chk("R3 dial not yet", alarm, 0);
    chk("R9 high before", sys_rst_n, 1);
    wait_cyc(1);
    chk("R3 dial expired", alarm, 1);
    chk("R9 pulse low", sys_rst_n, 0);
    wait_cyc(PUL - 1);
    chk("R9 still low", sys_rst_n, 0);
    wait_cyc(1);
    chk("R9 released", sys_rst_n, 1);
    wait_cyc(5);
    chk("R5 alarm held", alarm, 1);
    tmo_sel = 4'd0;
    wait_cyc(1);
    chk("R5 alarm cleared", alarm, 0);
  endtask

  task automatic t_strap_revert();
    do_reset();
    sw_sel = 1'b1;
    tmo_sel = 4'd1;
    pulse_fsel(5'd7);
    chk("R12 sw code", freq_code, 7);
    wait_cyc(SEC - 1);
    chk("R3 fsel not yet", alarm, 0);
    hw_code = 5'd21;
    wait_cyc(1);
    chk("R3 fsel expired", alarm, 1);
    chk("R6 strap code", freq_code, 21);
    hw_code = HW;
    wait_cyc(1);
    chk("R6 code held", freq_code, 21);
    tmo_sel = 4'd0;
    pulse_fsel(5'd9);
    chk("R12 new write ends revert", freq_code, 9);
    sw_sel = 1'b0;
    wait_cyc(1);
    chk("R12 strap when sw off", freq_code, HW);
  endtask

  task automatic t_prev_revert();
    do_reset();
    sw_sel = 1'b1; revert_prev = 1'b1;
    pulse_fsel(5'd18);
    tmo_sel = 4'd1;
    pulse_fsel(5'd4);
    wait_cyc(SEC);
    chk("R7 alarm", alarm, 1);
    chk("R7 previous code", freq_code, 18);
  endtask

  task automatic t_no_prev();
    do_reset();
    sw_sel = 1'b1; revert_prev = 1'b1; tmo_sel = 4'd1;
    pulse_fsel(5'd22);
    wait_cyc(SEC);
    chk("R8 alarm", alarm, 1);
    chk("R8 falls back to strap", freq_code, HW);
  endtask

  task automatic t_cancel();
    do_reset();
    sw_sel = 1'b1; tmo_sel = 4'd2;
    pulse_fsel(5'd11);
    wait_cyc(SEC);
    tmo_sel = 4'd0;
    wait_cyc(3 * SEC);
    chk("R4 no alarm", alarm, 0);
    chk("R4 no pulse", sys_rst_n, 1);
    chk("R4 code kept", freq_code, 11);
  endtask

  task automatic t_stop_mode();
    do_reset();
    pin_stop_mode = 1'b1; tmo_sel = 4'd1;
    pulse_dial();
    wait_cyc(SEC);
    chk("R10 alarm set", alarm, 1);
    for (int i = 0; i < PUL + 1; i++) begin
      chk("R10 pin high", sys_rst_n, 1);
      wait_cyc(1);
    end
  endtask

  task automatic t_restart();
    do_reset();
    tmo_sel = 4'd1;
    pulse_dial();
    wait_cyc(10);
    pulse_fsel(5'd3);
    wait_cyc(SEC - 1);
    chk("R11 restarted, no alarm", alarm, 0);
    wait_cyc(1);
    chk("R11 alarm after full period", alarm, 1);
  endtask

  initial begin
    t_reset_state();
    t_no_arm();
    t_dial_expiry();
    t_strap_revert();
    t_prev_revert();
    t_no_prev();
    t_cancel();
    t_stop_mode();
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule